// File: doc/BRIEF.md
# Cascadable Priority Encoder Slice

This block looks at eight request lines and reports, as a three-bit code, which asserted request has the highest priority. Requests, the enable and the code are all active low. Index 7 outranks every other request and index 0 ranks last. The code is the bitwise inverse of the winning index, so a win by request 7 drives `000` and a win by request 0 drives `111`.

Two status pins support chaining identical slices into a wider encoder. `next_en_n` feeds the enable of the next lower-ranked slice. It goes low only when this slice is enabled and sees no request, which passes the grant downward. `any_hit_n` goes low when this slice is enabled and holds at least one request. Glue logic outside the slice can use it to form the upper bits of a wide code. The block is purely combinational and has no clock or reset. It has no data stream, so it uses no valid/ready handshake. Every pin is a plain level.

Top module: `prio_enc_slice`

## Requirements
- R1: When enabled (`en_n`=0) with at least one request low, `code_n` equals the bitwise inverse of the highest index i for which `req_n[i]`=0. Request 7 alone gives `000`, and request 0 alone gives `111`.
- R2: Requests below the winning index have no effect on `code_n`. For example, all eight requests low gives `000`.
- R3: When disabled (`en_n`=1), `code_n`=`111`, `next_en_n`=1 and `any_hit_n`=1, whatever the requests are.
- R4: When enabled with at least one request low, `next_en_n`=1 and `any_hit_n`=0.
- R5: When enabled with every request high, `code_n`=`111`, `next_en_n`=0 and `any_hit_n`=1.
- R6: `next_en_n` and `any_hit_n` are never both 0.
- R7: The outputs depend only on the present inputs. They take no clock and hold no state, and they settle in the same time step as an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 8 | Request lines, active low; bit 7 has the highest priority |
| en_n | input | 1 | Slice enable, active low |
| code_n | output | 3 | Inverted index of the winning request |
| next_en_n | output | 1 | Low when enabled with no request; drives the enable of a lower-ranked slice |
| any_hit_n | output | 1 | Low when enabled with at least one request |

## Verification
Every result is due zero cycles after its stimulus, because no register sits between any input and any output. The bench changes inputs on the falling clock edge and samples the outputs one nanosecond later, inside the same clock period, before any further input change. A table of hand-computed vectors covers the priority corners. An exhaustive sweep then applies all 512 combinations of enable and requests and compares each against a reference that scans the requests from the top index downward.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  // {next_en_n, any_hit_n} pairs for the three operating cases
  typedef enum logic [1:0] {
    ST_OFF  = 2'b11,
    ST_HIT  = 2'b10,
    ST_IDLE = 2'b01
  } slice_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/prio_first_hit.sv
// Marks the single highest-ranked active request as a one-hot vector.
module prio_first_hit #(
  parameter int unsigned N_REQ = 8
) (
  input  logic [N_REQ-1:0] act,
  output logic [N_REQ-1:0] win
);
  logic [N_REQ:0] blocked;
  assign blocked[N_REQ] = 1'b0;

  for (genvar i = N_REQ - 1; i >= 0; i--) begin : g_rank
    assign win[i]     = act[i] & ~blocked[i+1];
    assign blocked[i] = blocked[i+1] | act[i];
  end
endmodule

// File: rtl/prio_onehot_idx.sv
// Turns a one-hot vector into its binary index (zero when empty).
module prio_onehot_idx #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = prio_enc_pkg::idx_width(N_REQ)
) (
  input  logic [N_REQ-1:0] onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int unsigned i = 0; i < N_REQ; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
  assign any = |onehot;
endmodule

// File: rtl/prio_enc_slice.sv
module prio_enc_slice #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = prio_enc_pkg::idx_width(N_REQ)
) (
  input  logic [N_REQ-1:0] req_n,
  input  logic             en_n,
  output logic [IDX_W-1:0] code_n,
  output logic             next_en_n,
  output logic             any_hit_n
);
  import prio_enc_pkg::*;

  logic [N_REQ-1:0] win;
  logic [IDX_W-1:0] idx;
  logic             any;
  slice_state_e     state;

  prio_first_hit #(.N_REQ(N_REQ)) u_first (
    .act (~req_n),
    .win (win)
  );

  prio_onehot_idx #(.N_REQ(N_REQ)) u_idx (
    .onehot (win),
    .idx    (idx),
    .any    (any)
  );

  always_comb begin
    if (en_n)     state = ST_OFF;
    else if (any) state = ST_HIT;
    else          state = ST_IDLE;
  end

  assign code_n                 = (state == ST_HIT) ? ~idx : '1;
  assign {next_en_n, any_hit_n} = state;
endmodule

// File: rtl/prio_enc_slice_chk.sv
module prio_enc_slice_chk #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IDX_W = prio_enc_pkg::idx_width(N_REQ)
) (
  input logic [N_REQ-1:0] req_n,
  input logic             en_n,
  input logic [IDX_W-1:0] code_n,
  input logic             next_en_n,
  input logic             any_hit_n
);
  logic [IDX_W-1:0] won;
  logic             upper_quiet;

  always_comb begin
    won = ~code_n;
    upper_quiet = 1'b1;
    for (int unsigned i = 0; i < N_REQ; i++) begin
      if (i > int'(won) && !req_n[i]) upper_quiet = 1'b0;
    end
  end

  always_comb begin
    // R3
    disabled_quiet_chk: assert (!en_n || (code_n == '1 && next_en_n && any_hit_n));
    // R4
    hit_status_chk: assert (en_n || &req_n || (next_en_n && !any_hit_n));
    // R5
    idle_status_chk: assert (en_n || !(&req_n) || (code_n == '1 && !next_en_n && any_hit_n));
    // R1
    winner_active_chk: assert (any_hit_n || !req_n[won]);
    // R2
    winner_top_chk: assert (any_hit_n || upper_quiet);
    // R6
    status_excl_chk: assert (next_en_n || any_hit_n);
  end
endmodule

bind prio_enc_slice prio_enc_slice_chk #(.N_REQ(N_REQ)) u_chk (
  .req_n     (req_n),
  .en_n      (en_n),
  .code_n    (code_n),
  .next_en_n (next_en_n),
  .any_hit_n (any_hit_n)
);

// File: tb/prio_enc_slice_tb_top.sv
module prio_enc_slice_tb_top;
  logic       clk = 1'b0;
  logic [7:0] req_n;
  logic       en_n;
  logic [2:0] code_n;
  logic       next_en_n;
  logic       any_hit_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  prio_enc_slice dut_i (
    .req_n     (req_n),
    .en_n      (en_n),
    .code_n    (code_n),
    .next_en_n (next_en_n),
    .any_hit_n (any_hit_n)
  );

  // {en_n, req_n, code_n, next_en_n, any_hit_n}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 8'h00, 3'b111, 1'b1, 1'b1},
    {1'b0, 8'hFF, 3'b111, 1'b0, 1'b1},
    {1'b0, 8'h7F, 3'b000, 1'b1, 1'b0},
    {1'b0, 8'hFE, 3'b111, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0},
    {1'b0, 8'h80, 3'b001, 1'b1, 1'b0},
    {1'b0, 8'hEF, 3'b011, 1'b1, 1'b0},
    {1'b0, 8'hF5, 3'b100, 1'b1, 1'b0},
    {1'b1, 8'h7F, 3'b111, 1'b1, 1'b1},
    {1'b0, 8'hBF, 3'b001, 1'b1, 1'b0}
  };

  function automatic logic [4:0] ref_model(input logic e, input logic [7:0] r);
    if (e) return 5'b111_1_1;
    for (int i = 7; i >= 0; i--) begin
      if (!r[i]) return {~3'(i), 1'b1, 1'b0};
    end
    return 5'b111_0_1;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s en_n=%b req_n=%h actual=%b expected=%b", req, en_n, req_n, act, exp);
    end
  endtask

  task automatic apply(input logic e, input logic [7:0] r);
    @(negedge clk);
    en_n  = e;
    req_n = r;
    #1;
  endtask

  initial begin
    en_n  = 1'b1;
    req_n = 8'hFF;
    #1;
    // R3 R7: idle state with no clock edge seen yet
    check("R3/R7 start", {code_n, next_en_n, any_hit_n}, 5'b111_1_1);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][13], VEC[k][12:5]);
      check("R1/R2/R3/R4/R5 table", {code_n, next_en_n, any_hit_n}, VEC[k][4:0]);
    end

    // R1: each single request in turn
    for (int i = 0; i < 8; i++) begin
      apply(1'b0, ~(8'h01 << i));
      check("R1 single", {code_n, next_en_n, any_hit_n}, {~3'(i), 2'b10});
    end

    // R2: lower requests changing under a held request 5 leave code at 010
    for (int m = 0; m < 32; m++) begin
      apply(1'b0, {3'b110, 5'(m)});
      check("R2 masked", {1'b0, code_n, 1'b0}, {1'b0, 3'b010, 1'b0});
    end

    // R7: settles within the step with no clock edge between
    @(negedge clk);
    en_n = 1'b0; req_n = 8'hFD;
    #0.5;
    check("R7 same step", {code_n, next_en_n, any_hit_n}, 5'b110_1_0);

    // R3 R4 R5 R6: exhaustive sweep
    for (int v = 0; v < 512; v++) begin
      apply(v[8], v[7:0]);
      check("R3/R4/R5 sweep", {code_n, next_en_n, any_hit_n}, ref_model(v[8], v[7:0]));
      check("R6 excl", {4'b0, next_en_n | any_hit_n}, 5'b00001);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule